// File: doc/BRIEF.md
# Board System Control Register Bank

This block is a 4 KB window of 32-bit control and identity registers on a simple single-cycle bus. Software uses it to hold a few general configuration words, to light a row of board LEDs, to read fixed identity values chosen when the block is built, and to watch a set of clock-lock inputs through a status word whose summary bit honours a writable mask.

The identity word carries a 12-bit part-number field. That field decides which optional configuration words exist for a given board variant. On a variant that lacks a word, its offset behaves like any unused offset: reads return zero and writes are dropped. The configuration-channel window higher in the map is not implemented here and decodes as unused space.

A bus access is presented for one cycle with `bus_valid` high. A write takes effect at that clock edge. A read returns its word on `bus_rdata` after that same edge, and the word is held until the next read.

Top module: `board_ctrl_regs`

## Requirements
- R1: On reset, the general words at 0x000, 0x004, 0x008, 0x014 and 0x018 become zero, all LED outputs go low, `bus_rdata` is zero and the lock mask becomes 0xFF. A read of 0x100 with all lock inputs high then returns 0xFFFF0001.
- R2: A read accepted at a clock edge places its data on `bus_rdata` after that edge. `bus_rdata` keeps its value through idle cycles and write cycles.
- R3: The words at 0x000 and 0x004 store all 32 written bits and read them back unchanged.
- R4: LED output i equals bit i of the word at 0x004, active high. The outputs change in the cycle after a write to 0x004 and at no other time.
- R5: The part number is bits [15:4] of `ID_VAL`. The words at 0x008 and 0x014 are writable and readable only when the part number is 0x524 or 0x547.
- R6: The word at 0x018 is writable and readable only when the part number is 0x524.
- R7: A read of any unused, absent-variant or non-word-aligned offset returns zero, and a write to one changes no register. This includes the configuration-channel window 0x0A0 to 0x0AC and any address with bits [1:0] not zero.
- R8: A read of 0x00C always returns zero. A read of 0x010 returns `CFG4_VAL`, of 0xFF8 `AID_VAL` and of 0xFFC `ID_VAL`. Writes to these four offsets have no effect.
- R9: The word at 0x100 holds the lock mask in bits [31:24], the lock inputs as sampled at the read edge in bits [23:16], and zero in bits [15:1]. A write to it changes only bits [31:24].
- R10: Bit 0 of the word at 0x100 is one exactly when every lock input whose mask bit is one is high. With a zero mask it is one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr | input | 12 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| led_o | output | LED_CNT | LED drive, active high |
| dll_locked_i | input | 8 | Per-channel clock-lock indications |

## Verification
A wrong stored word or a wrong variant decode shows on `bus_rdata` one cycle after the next read of that offset. A wrong LED word shows on `led_o` in the cycle right after the write. A wrong lock mask or a wrong summary fold shows in the 0x100 word on the first read after the mask write or the lock-input change. Three instances with different part numbers get the same bus traffic, so a decode fault in any one variant appears as a read-data mismatch within a cycle.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int LOCK_CH = 8;

    localparam logic [ADDR_W-1:0] OFF_CFG0 = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CFG1 = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_CFG2 = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_CFG3 = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_CFG4 = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_CFG5 = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_CFG6 = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_LOCK = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_AID  = 12'hFF8;
    localparam logic [ADDR_W-1:0] OFF_ID   = 12'hFFC;

    localparam logic [11:0] PART_FULL = 12'h524;
    localparam logic [11:0] PART_ALT  = 12'h547;

    localparam logic [LOCK_CH-1:0] LOCK_MASK_RST = '1;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG0,
        SEL_CFG1,
        SEL_CFG2,
        SEL_CFG3,
        SEL_CFG4,
        SEL_CFG5,
        SEL_CFG6,
        SEL_LOCK,
        SEL_AID,
        SEL_ID
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    localparam int NUM_STORE = 5;

    function automatic reg_sel_e store_slot(input int idx);
        case (idx)
            0:       return SEL_CFG0;
            1:       return SEL_CFG1;
            2:       return SEL_CFG2;
            3:       return SEL_CFG5;
            default: return SEL_CFG6;
        endcase
    endfunction

    function automatic logic [11:0] part_of(input logic [DATA_W-1:0] id_word);
        return id_word[15:4];
    endfunction

    function automatic logic part_has_mid(input logic [11:0] part);
        return (part == PART_FULL) || (part == PART_ALT);
    endfunction

    function automatic logic part_has_top(input logic [11:0] part);
        return part == PART_FULL;
    endfunction

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] addr,
                                               input logic [11:0] part);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            case (addr)
                OFF_CFG0: sel = SEL_CFG0;
                OFF_CFG1: sel = SEL_CFG1;
                OFF_CFG2: sel = part_has_mid(part) ? SEL_CFG2 : SEL_NONE;
                OFF_CFG3: sel = SEL_CFG3;
                OFF_CFG4: sel = SEL_CFG4;
                OFF_CFG5: sel = part_has_mid(part) ? SEL_CFG5 : SEL_NONE;
                OFF_CFG6: sel = part_has_top(part) ? SEL_CFG6 : SEL_NONE;
                OFF_LOCK: sel = SEL_LOCK;
                OFF_AID:  sel = SEL_AID;
                OFF_ID:   sel = SEL_ID;
                default:  sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

    function automatic logic lock_summary(input logic [LOCK_CH-1:0] locked,
                                          input logic [LOCK_CH-1:0] mask);
        return &(locked | ~mask);
    endfunction

endpackage

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
    import board_ctrl_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VAL = 32'h4105_5240
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_req_t          req
);

    localparam logic [11:0] PART = part_of(ID_VAL);

    always_comb begin
        req.rd    = bus_valid && !bus_write;
        req.wr    = bus_valid && bus_write;
        req.sel   = decode_offset(bus_addr, PART);
        req.wdata = bus_wdata;
    end

endmodule

// File: rtl/board_ctrl_store.sv
module board_ctrl_store
    import board_ctrl_pkg::*;
#(
    parameter int NUM = NUM_STORE
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  reg_sel_e                    wr_sel,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [NUM-1:0][DATA_W-1:0]  word_q
);

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        localparam reg_sel_e MY_SEL = store_slot(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[g] <= '0;
            end else if (wr_en && (wr_sel == MY_SEL)) begin
                word_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/board_ctrl_lock_stat.sv
module board_ctrl_lock_stat
    import board_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_sel_e           wr_sel,
    input  logic [LOCK_CH-1:0] mask_wdata,
    input  logic [LOCK_CH-1:0] locked_i,
    output logic [DATA_W-1:0]  stat_word
);

    localparam int PAD_W = DATA_W - 2 * LOCK_CH - 1;

    logic [LOCK_CH-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= LOCK_MASK_RST;
        end else if (wr_en && (wr_sel == SEL_LOCK)) begin
            mask_q <= mask_wdata;
        end
    end

    always_comb begin
        stat_word = {mask_q, locked_i, {PAD_W{1'b0}}, lock_summary(locked_i, mask_q)};
    end

endmodule

// File: rtl/board_ctrl_rd_path.sv
module board_ctrl_rd_path
    import board_ctrl_pkg::*;
#(
    parameter logic [DATA_W-1:0] CFG4_VAL = 32'h0000_0003,
    parameter logic [DATA_W-1:0] AID_VAL  = 32'h0220_0A11,
    parameter logic [DATA_W-1:0] ID_VAL   = 32'h4105_5240
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              rd_en,
    input  reg_sel_e                          rd_sel,
    input  logic [NUM_STORE-1:0][DATA_W-1:0]  store_q,
    input  logic [DATA_W-1:0]                 stat_word,
    output logic [DATA_W-1:0]                 rdata
);

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        case (rd_sel)
            SEL_CFG0: rd_mux = store_q[0];
            SEL_CFG1: rd_mux = store_q[1];
            SEL_CFG2: rd_mux = store_q[2];
            SEL_CFG5: rd_mux = store_q[3];
            SEL_CFG6: rd_mux = store_q[4];
            SEL_CFG4: rd_mux = CFG4_VAL;
            SEL_LOCK: rd_mux = stat_word;
            SEL_AID:  rd_mux = AID_VAL;
            SEL_ID:   rd_mux = ID_VAL;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import board_ctrl_pkg::*;
#(
    parameter int                LED_CNT  = 8,
    parameter logic [DATA_W-1:0] CFG4_VAL = 32'h0000_0003,
    parameter logic [DATA_W-1:0] AID_VAL  = 32'h0220_0A11,
    parameter logic [DATA_W-1:0] ID_VAL   = 32'h4105_5240
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [LED_CNT-1:0] led_o,
    input  logic [LOCK_CH-1:0] dll_locked_i
);

    localparam int MASK_LSB = DATA_W - LOCK_CH;

    bus_req_t                            req;
    logic [NUM_STORE-1:0][DATA_W-1:0]    store_q;
    logic [DATA_W-1:0]                   stat_word;

    board_ctrl_decode #(.ID_VAL(ID_VAL)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req       (req)
    );

    board_ctrl_store #(.NUM(NUM_STORE)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req.wr),
        .wr_sel  (req.sel),
        .wr_data (req.wdata),
        .word_q  (store_q)
    );

    board_ctrl_lock_stat u_lock (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (req.wr),
        .wr_sel     (req.sel),
        .mask_wdata (req.wdata[DATA_W-1:MASK_LSB]),
        .locked_i   (dll_locked_i),
        .stat_word  (stat_word)
    );

    board_ctrl_rd_path #(
        .CFG4_VAL (CFG4_VAL),
        .AID_VAL  (AID_VAL),
        .ID_VAL   (ID_VAL)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (req.rd),
        .rd_sel    (req.sel),
        .store_q   (store_q),
        .stat_word (stat_word),
        .rdata     (bus_rdata)
    );

    assign led_o = store_q[1][LED_CNT-1:0];

endmodule

// File: rtl/board_ctrl_regs_chk.sv
module board_ctrl_regs_chk
    import board_ctrl_pkg::*;
#(
    parameter int                LED_CNT = 8,
    parameter logic [DATA_W-1:0] ID_VAL  = 32'h4105_5240
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [LED_CNT-1:0] led_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [LED_CNT-1:0] led_o,
    input logic [LOCK_CH-1:0] dll_locked_i
);

    logic rd_now;
    logic led_wr_now;
    assign rd_now     = bus_valid && !bus_write;
    assign led_wr_now = bus_valid && bus_write && (bus_addr == OFF_CFG1);

    AST_RESET_LEDS_OFF: assert property (@(posedge clk)
        rst |=> (led_o == '0 && bus_rdata == '0));                          // R1

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_now |=> $stable(bus_rdata));                                    // R2

    AST_LED_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        led_wr_now |=> (led_o == $past(led_wdata)));                        // R4

    AST_LED_STEADY: assert property (@(posedge clk) disable iff (rst)
        !led_wr_now |=> $stable(led_o));                                    // R4

    AST_UNALIGNED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_now && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));          // R7

    AST_CFG3_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_now && bus_addr == OFF_CFG3) |=> (bus_rdata == '0));            // R8

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        (rd_now && bus_addr == OFF_ID) |=> (bus_rdata == ID_VAL));          // R8

    AST_LOCK_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (rd_now && bus_addr == OFF_LOCK) |=>
            (bus_rdata[23:16] == $past(dll_locked_i) && bus_rdata[15:1] == '0)); // R9

    AST_LOCK_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        (rd_now && bus_addr == OFF_LOCK) |=>
            (bus_rdata[0] == &($past(dll_locked_i) | ~bus_rdata[31:24])));  // R10

endmodule

bind board_ctrl_regs board_ctrl_regs_chk #(
    .LED_CNT (LED_CNT),
    .ID_VAL  (ID_VAL)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .led_wdata    (bus_wdata[LED_CNT-1:0]),
    .bus_rdata    (bus_rdata),
    .led_o        (led_o),
    .dll_locked_i (dll_locked_i)
);

// File: tb/board_ctrl_regs_tb.sv
`timescale 1ns/1ps
module board_ctrl_regs_tb;

    localparam logic [31:0] CFG4_V = 32'h0000_0003;
    localparam logic [31:0] AID_V  = 32'h0220_0A11;
    localparam logic [31:0] ID_A   = 32'h4105_5240;
    localparam logic [31:0] ID_B   = 32'h4105_5470;
    localparam logic [31:0] ID_C   = 32'h4104_5110;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 12'h000, 32'h0000_0000, 4'd1},  // R1
        '{1'b0, 12'h004, 32'h0000_0000, 4'd1},
        '{1'b1, 12'h000, 32'hA5A5_1234, 4'd3},  // R3
        '{1'b0, 12'h000, 32'hA5A5_1234, 4'd3},
        '{1'b1, 12'h004, 32'h0000_00C3, 4'd3},
        '{1'b0, 12'h004, 32'h0000_00C3, 4'd3},
        '{1'b1, 12'h008, 32'h1111_2222, 4'd5},  // R5
        '{1'b0, 12'h008, 32'h1111_2222, 4'd5},
        '{1'b1, 12'h014, 32'h3333_4444, 4'd5},
        '{1'b0, 12'h014, 32'h3333_4444, 4'd5},
        '{1'b1, 12'h018, 32'h5555_6666, 4'd6},  // R6
        '{1'b0, 12'h018, 32'h5555_6666, 4'd6},
        '{1'b1, 12'h00C, 32'hFFFF_FFFF, 4'd8},  // R8
        '{1'b0, 12'h00C, 32'h0000_0000, 4'd8},
        '{1'b1, 12'h010, 32'hFFFF_FFFF, 4'd8},
        '{1'b0, 12'h010, CFG4_V,        4'd8},
        '{1'b0, 12'hFF8, AID_V,         4'd8},
        '{1'b1, 12'hFFC, 32'h0000_0000, 4'd8},
        '{1'b0, 12'hFFC, ID_A,          4'd8},
        '{1'b1, 12'h0A4, 32'hDEAD_BEEF, 4'd7},  // R7
        '{1'b0, 12'h0A4, 32'h0000_0000, 4'd7},
        '{1'b0, 12'h002, 32'h0000_0000, 4'd7},
        '{1'b1, 12'h001, 32'hFFFF_FFFF, 4'd7},
        '{1'b0, 12'h000, 32'hA5A5_1234, 4'd7},
        '{1'b0, 12'h100, 32'hFFFF_0001, 4'd9},  // R9
        '{1'b1, 12'h100, 32'h0F00_FFFF, 4'd9},
        '{1'b0, 12'h100, 32'h0FFF_0001, 4'd9},
        '{1'b0, 12'h0A8, 32'h0000_0000, 4'd7},
        '{1'b0, 12'h800, 32'h0000_0000, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  locked = 8'hFF;
    logic [31:0] rdata_a, rdata_b, rdata_c;
    logic [7:0]  led_a, led_b, led_c;

    int n_checks = 0;
    int n_err    = 0;

    always #4 clk = ~clk;

    board_ctrl_regs #(.LED_CNT(8), .CFG4_VAL(CFG4_V), .AID_VAL(AID_V), .ID_VAL(ID_A)) u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .led_o(led_a), .dll_locked_i(locked));

    board_ctrl_regs #(.LED_CNT(8), .CFG4_VAL(CFG4_V), .AID_VAL(AID_V), .ID_VAL(ID_B)) u_dut_alt (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .led_o(led_b), .dll_locked_i(locked));

    board_ctrl_regs #(.LED_CNT(8), .CFG4_VAL(CFG4_V), .AID_VAL(AID_V), .ID_VAL(ID_C)) u_dut_min (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_c),
        .led_o(led_c), .dll_locked_i(locked));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let the rising edge take it, sample at the next falling edge.
    task automatic bus_op(input logic wr, input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = addr;
        bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset rdata", rdata_a, 32'h0);
        check("R1 reset leds", {24'h0, led_a}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_op(VECS[i].wr, VECS[i].addr, VECS[i].data);
            if (!VECS[i].wr)
                check($sformatf("R%0d vector %0d", VECS[i].tag, i), rdata_a, VECS[i].data);
        end

        // R5 and R6 across variants
        bus_op(1'b0, 12'h008, 32'h0);
        check("R5 alt variant 0x008", rdata_b, 32'h1111_2222);
        check("R5 minimal variant 0x008", rdata_c, 32'h0);
        bus_op(1'b0, 12'h014, 32'h0);
        check("R5 alt variant 0x014", rdata_b, 32'h3333_4444);
        check("R5 minimal variant 0x014", rdata_c, 32'h0);
        bus_op(1'b0, 12'h018, 32'h0);
        check("R6 full variant 0x018", rdata_a, 32'h5555_6666);
        check("R6 alt variant 0x018", rdata_b, 32'h0);
        check("R6 minimal variant 0x018", rdata_c, 32'h0);
        bus_op(1'b0, 12'h000, 32'h0);
        check("R3 minimal variant 0x000", rdata_c, 32'hA5A5_1234);

        // R4 LED drive
        bus_op(1'b1, 12'h004, 32'hFFFF_FF5A);
        check("R4 leds after write", {24'h0, led_a}, 32'h0000_005A);
        check("R4 leds minimal variant", {24'h0, led_c}, 32'h0000_005A);
        bus_op(1'b1, 12'h000, 32'h0000_0000);
        check("R4 leds unchanged by other write", {24'h0, led_a}, 32'h0000_005A);

        // R2 read data hold
        bus_op(1'b0, 12'hFFC, 32'h0);
        idle();
        check("R2 hold over idle", rdata_a, ID_A);
        bus_op(1'b1, 12'h000, 32'h1234_5678);
        check("R2 hold over write", rdata_a, ID_A);

        // R9 / R10 lock word, mask is 0x0F here
        locked = 8'hF0;
        bus_op(1'b0, 12'h100, 32'h0);
        check("R10 masked channel unlocked", rdata_a, 32'h0FF0_0000);
        locked = 8'h0F;
        bus_op(1'b0, 12'h100, 32'h0);
        check("R10 masked channels locked", rdata_a, 32'h0F0F_0001);
        bus_op(1'b1, 12'h100, 32'h00FF_FFFF);
        locked = 8'h00;
        bus_op(1'b0, 12'h100, 32'h0);
        check("R10 zero mask summary", rdata_a, 32'h0000_0001);
        check("R9 low bits alt variant", rdata_b, 32'h0000_0001);

        // R1 reset again
        locked = 8'hFF;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 leds after reset", {24'h0, led_a}, 32'h0);
        bus_op(1'b0, 12'h000, 32'h0);
        check("R1 word cleared", rdata_a, 32'h0);
        bus_op(1'b0, 12'h018, 32'h0);
        check("R1 top word cleared", rdata_a, 32'h0);
        bus_op(1'b0, 12'h100, 32'h0);
        check("R1 lock mask restored", rdata_a, 32'hFFFF_0001);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule